// File: doc/BRIEF.md
# Tagged Insert-Delete Linear Sorter

The block keeps a short list of (tag, data) entries in tag order inside a row of identical nodes. Each cycle it can take one new entry, which every node sees at once, and one request to remove the entry at the head. No central controller picks a slot. Each node looks at its own entry, at its two neighbours and at the broadcast entry, then chooses one of four operations for that cycle: OP_HOLD (keep the entry), OP_INSERT (load the broadcast entry), OP_FROM_LEFT (take the left neighbour's entry, moving it toward the tail) or OP_FROM_RIGHT (take the right neighbour's entry, moving it toward the head).

The decision depends on the cycle's request. With no request every node stays in OP_HOLD. A remove request alone sends every node to OP_FROM_RIGHT. An insert request alone makes later-ranked entries shift toward the tail, and exactly one node moves to OP_INSERT. When both requests arrive together, the nodes choose between OP_FROM_RIGHT, OP_INSERT and OP_HOLD, so the head leaves and the new entry lands in order in the same cycle.

Upstream logic watches the almost-full flag to know when to start holding entries back. Downstream logic reads the head entry, or every node at once, and decides when to remove. Tag width, data width, depth and sort direction are parameters.

Top module: `tagged_linear_sorter`

## Requirements
- R1: While `rst` is high at a clock edge, every node becomes empty, so after reset `node_valid` is all zero and `head_valid` is 0.
- R2: An insertion without a remove puts the new entry at its ranked place. Valid entries fill nodes 0 upward with no gaps, and the list stays in order. With ASCEND=1, tags never decrease from node 0 upward. Node i appears at `node_tags[i*TAG_W +: TAG_W]` and `node_data[i*DATA_W +: DATA_W]`. An entry that ranks last is appended in the first empty node.
- R3: A new entry whose tag equals one or more stored tags is placed after all of them.
- R4: A remove without an insertion drops the node-0 entry and moves every other entry one node toward the head.
- R5: An insertion and a remove in the same cycle drop the old head and place the new entry in order among the rest, leaving the entry count unchanged.
- R6: An insertion into a full list without a remove keeps the DEPTH best-ranked entries of the old entries plus the new one. The single last-ranked entry is discarded, and that may be the new entry itself.
- R7: A remove request while the list is empty changes nothing.
- R8: `almost_full` is high, in the same cycle and combinationally, exactly when `ins_valid` is high and exactly DEPTH-1 nodes hold entries.
- R9: With ASCEND=0 every comparison is reversed, so the largest tag sits at node 0. The rules for ties, removal and discard then follow the reversed ranking.
- R10: `head_valid`, `head_tag` and `head_data` always show node 0's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Insert request this cycle |
| ins_tag | input | TAG_W | Tag of the new entry |
| ins_data | input | DATA_W | Data of the new entry |
| del_req | input | 1 | Remove the head entry this cycle |
| head_valid | output | 1 | Node 0 holds an entry |
| head_tag | output | TAG_W | Node 0 tag |
| head_data | output | DATA_W | Node 0 data |
| node_valid | output | DEPTH | Valid bit of each node, bit i for node i |
| node_tags | output | DEPTH*TAG_W | All tags, node i at bits i*TAG_W upward |
| node_data | output | DEPTH*DATA_W | All data words, node i at bits i*DATA_W upward |
| almost_full | output | 1 | Insertion while one node remains free |

## Verification
The assertions assume that `rst` is held high over the first clock edge, so that the no-gap and ordering properties start from an empty list. They make no assumption about request patterns: any mix of insert and remove, including a remove while empty or an insert while full, must keep the list ordered. The bench changes inputs only between clock edges and starts every swept scenario from reset. It fills the list to each level with tags that arrive out of order and include values that later collide. It then drives each possible new tag under each kind of request, and finishes with a long pseudo-random request stream.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
    typedef enum logic [1:0] {
        OP_HOLD       = 2'd0,
        OP_INSERT     = 2'd1,
        OP_FROM_LEFT  = 2'd2,
        OP_FROM_RIGHT = 2'd3
    } node_op_e;
endpackage

// File: rtl/sort_node.sv
module sort_node
    import sorter_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int DATA_W  = 8,
    parameter bit ASCEND  = 1'b1,
    parameter bit IS_HEAD = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_v,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              del,
    input  logic              l_v,
    input  logic [TAG_W-1:0]  l_tag,
    input  logic [DATA_W-1:0] l_data,
    input  logic              r_v,
    input  logic [TAG_W-1:0]  r_tag,
    input  logic [DATA_W-1:0] r_data,
    output logic              q_v,
    output logic [TAG_W-1:0]  q_tag,
    output logic [DATA_W-1:0] q_data
);
    node_op_e op;
    logic     nb_own, nb_left, nb_right;

    // new tag strictly ranks before the compared tag
    assign nb_own   = ASCEND ? (ins_tag < q_tag) : (ins_tag > q_tag);
    assign nb_left  = ASCEND ? (ins_tag < l_tag) : (ins_tag > l_tag);
    assign nb_right = ASCEND ? (ins_tag < r_tag) : (ins_tag > r_tag);

    always_comb begin
        op = OP_HOLD;
        if (ins_v && del) begin
            if (r_v && !nb_right)
                op = OP_FROM_RIGHT;
            else if (IS_HEAD || (q_v && !nb_own))
                op = OP_INSERT;
        end else if (del) begin
            op = OP_FROM_RIGHT;
        end else if (ins_v) begin
            if (q_v ? nb_own : (IS_HEAD || l_v))
                op = (!IS_HEAD && l_v && nb_left) ? OP_FROM_LEFT : OP_INSERT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_v <= 1'b0;
        end else begin
            unique case (op)
                OP_HOLD: ;
                OP_INSERT: begin
                    q_v    <= 1'b1;
                    q_tag  <= ins_tag;
                    q_data <= ins_data;
                end
                OP_FROM_LEFT: begin
                    q_v    <= l_v;
                    q_tag  <= l_tag;
                    q_data <= l_data;
                end
                OP_FROM_RIGHT: begin
                    q_v    <= r_v;
                    q_tag  <= r_tag;
                    q_data <= r_data;
                end
                default: ;
            endcase
        end
    end

    // R2
    insert_keeps_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_v && !del && q_v) |=> q_v);
endmodule

// File: rtl/sort_flags.sv
module sort_flags #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] vld,
    input  logic             ins_v,
    output logic             almost_full
);
    assign almost_full = ins_v && ($countones(vld) == DEPTH - 1);
endmodule

// File: rtl/tagged_linear_sorter.sv
module tagged_linear_sorter
    import sorter_pkg::*;
#(
    parameter int TAG_W  = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter bit ASCEND = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ins_valid,
    input  logic [TAG_W-1:0]        ins_tag,
    input  logic [DATA_W-1:0]       ins_data,
    input  logic                    del_req,
    output logic                    head_valid,
    output logic [TAG_W-1:0]        head_tag,
    output logic [DATA_W-1:0]       head_data,
    output logic [DEPTH-1:0]        node_valid,
    output logic [DEPTH*TAG_W-1:0]  node_tags,
    output logic [DEPTH*DATA_W-1:0] node_data,
    output logic                    almost_full
);
    localparam int EXT = DEPTH + 2;

    logic              v_ext [0:EXT-1];
    logic [TAG_W-1:0]  t_ext [0:EXT-1];
    logic [DATA_W-1:0] d_ext [0:EXT-1];
    logic              del_eff;

    // R7: a remove only acts when node 0 holds an entry
    assign del_eff = del_req && v_ext[1];

    assign v_ext[0]     = 1'b0;
    assign t_ext[0]     = '0;
    assign d_ext[0]     = '0;
    assign v_ext[EXT-1] = 1'b0;
    assign t_ext[EXT-1] = '0;
    assign d_ext[EXT-1] = '0;

    for (genvar i = 0; i < DEPTH; i++) begin : g_node
        sort_node #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W),
            .ASCEND (ASCEND),
            .IS_HEAD(i == 0)
        ) u_node (
            .clk     (clk),
            .rst     (rst),
            .ins_v   (ins_valid),
            .ins_tag (ins_tag),
            .ins_data(ins_data),
            .del     (del_eff),
            .l_v     (v_ext[i]),
            .l_tag   (t_ext[i]),
            .l_data  (d_ext[i]),
            .r_v     (v_ext[i+2]),
            .r_tag   (t_ext[i+2]),
            .r_data  (d_ext[i+2]),
            .q_v     (v_ext[i+1]),
            .q_tag   (t_ext[i+1]),
            .q_data  (d_ext[i+1])
        );
        assign node_valid[i]                 = v_ext[i+1];
        assign node_tags[i*TAG_W +: TAG_W]   = t_ext[i+1];
        assign node_data[i*DATA_W +: DATA_W] = d_ext[i+1];
    end

    assign head_valid = v_ext[1];
    assign head_tag   = t_ext[1];
    assign head_data  = d_ext[1];

    sort_flags #(.DEPTH(DEPTH)) u_flags (
        .vld        (node_valid),
        .ins_v      (ins_valid),
        .almost_full(almost_full)
    );

    // R1
    reset_empty_chk: assert property (@(posedge clk) rst |=> !head_valid);

    // R7
    empty_del_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!ins_valid && del_req && !head_valid) |=> (node_valid == '0));

    // R4
    del_moves_head_chk: assert property (@(posedge clk) disable iff (rst)
        (!ins_valid && del_req && node_valid[1]) |=> (head_tag == $past(node_tags[2*TAG_W-1:TAG_W])));

    // R8
    almost_full_fills_chk: assert property (@(posedge clk) disable iff (rst)
        (almost_full && !del_req) |=> node_valid[DEPTH-1]);

    // R8
    not_almost_full_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !almost_full && !del_req && !node_valid[DEPTH-1] && !node_valid[DEPTH-2]) |=> !node_valid[DEPTH-1]);

    for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_chk
        // R2
        no_gap_chk: assert property (@(posedge clk) disable iff (rst)
            node_valid[i+1] |-> node_valid[i]);
        // R2
        in_order_chk: assert property (@(posedge clk) disable iff (rst)
            node_valid[i+1] |-> (ASCEND ? (t_ext[i+2] >= t_ext[i+1]) : (t_ext[i+2] <= t_ext[i+1])));
    end
endmodule

// File: tb/tb_tagged_linear_sorter.sv
module tb_tagged_linear_sorter;
    localparam int TW = 3;
    localparam int DW = 4;
    localparam int D  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iv = 1'b0;
    logic dl = 1'b0;
    logic [TW-1:0] it = '0;
    logic [DW-1:0] idt = '0;

    logic          hv   [0:1];
    logic [TW-1:0] ht   [0:1];
    logic [DW-1:0] hd   [0:1];
    logic [D-1:0]  nv   [0:1];
    logic [D*TW-1:0] nt [0:1];
    logic [D*DW-1:0] nd [0:1];
    logic          af   [0:1];

    always #2 clk = ~clk;

    tagged_linear_sorter #(.TAG_W(TW), .DATA_W(DW), .DEPTH(D), .ASCEND(1'b1)) dut (
        .clk(clk), .rst(rst), .ins_valid(iv), .ins_tag(it), .ins_data(idt), .del_req(dl),
        .head_valid(hv[0]), .head_tag(ht[0]), .head_data(hd[0]),
        .node_valid(nv[0]), .node_tags(nt[0]), .node_data(nd[0]), .almost_full(af[0]));

    tagged_linear_sorter #(.TAG_W(TW), .DATA_W(DW), .DEPTH(D), .ASCEND(1'b0)) dut_desc (
        .clk(clk), .rst(rst), .ins_valid(iv), .ins_tag(it), .ins_data(idt), .del_req(dl),
        .head_valid(hv[1]), .head_tag(ht[1]), .head_data(hd[1]),
        .node_valid(nv[1]), .node_tags(nt[1]), .node_data(nd[1]), .almost_full(af[1]));

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [TW-1:0] mtag [0:1][0:D-1];
    logic [DW-1:0] mdat [0:1][0:D-1];
    int            mcnt [0:1];
    logic [DW-1:0] dcnt = '0;

    function automatic bit bef(int d, logic [TW-1:0] a, logic [TW-1:0] b);
        return (d == 0) ? (a < b) : (a > b);
    endfunction

    task automatic m_ins(int d, logic [TW-1:0] t, logic [DW-1:0] x);
        int p = 0;
        while (p < mcnt[d] && !bef(d, t, mtag[d][p])) p++;
        if (p >= D) return;
        for (int k = D - 1; k > p; k--) begin
            mtag[d][k] = mtag[d][k-1];
            mdat[d][k] = mdat[d][k-1];
        end
        mtag[d][p] = t;
        mdat[d][p] = x;
        if (mcnt[d] < D) mcnt[d]++;
    endtask

    task automatic m_pop(int d);
        for (int k = 0; k < D - 1; k++) begin
            mtag[d][k] = mtag[d][k+1];
            mdat[d][k] = mdat[d][k+1];
        end
        mcnt[d]--;
    endtask

    task automatic check_dut(int d, string req);
        logic [D-1:0]    ev = '0;
        logic [D*TW-1:0] et = '0, tm = '0;
        logic [D*DW-1:0] ed = '0, dm = '0;
        for (int i = 0; i < mcnt[d]; i++) begin
            ev[i] = 1'b1;
            et[i*TW +: TW] = mtag[d][i];
            ed[i*DW +: DW] = mdat[d][i];
            tm[i*TW +: TW] = '1;
            dm[i*DW +: DW] = '1;
        end
        checks++;
        if (nv[d] !== ev || (nt[d] & tm) !== et || (nd[d] & dm) !== ed) begin
            fails++;
            $display("FAIL %s dut%0d: valid=%b tags=%h data=%h expected valid=%b tags=%h data=%h",
                     req, d, nv[d], nt[d] & tm, nd[d] & dm, ev, et, ed);
        end
        checks++;
        if (hv[d] !== ev[0] || (ev[0] && (ht[d] !== et[TW-1:0] || hd[d] !== ed[DW-1:0]))) begin
            fails++;
            $display("FAIL R10 dut%0d: head v=%b t=%h d=%h expected v=%b t=%h d=%h",
                     d, hv[d], ht[d], hd[d], ev[0], et[TW-1:0], ed[DW-1:0]);
        end
    endtask

    function automatic string lbl(bit i, bit r);
        if (i && r) return "R5";
        if (r) return (mcnt[0] == 0) ? "R7" : "R4";
        if (i) return (mcnt[0] == D) ? "R6" : "R2";
        return "R2";
    endfunction

    task automatic do_op(bit i, logic [TW-1:0] t, bit r, string req);
        iv = i; it = t; idt = dcnt; dl = r;
        #1;
        for (int d = 0; d < 2; d++) begin
            checks++;
            if (af[d] !== (i && mcnt[d] == D - 1)) begin
                fails++;
                $display("FAIL R8 dut%0d: almost_full=%b expected %b", d, af[d], i && mcnt[d] == D - 1);
            end
        end
        @(posedge clk); #1;
        for (int d = 0; d < 2; d++) begin
            if (r && mcnt[d] > 0) begin
                m_pop(d);
                if (i) m_ins(d, t, dcnt);
            end else if (i) begin
                m_ins(d, t, dcnt);
            end
        end
        dcnt++;
        iv = 1'b0; dl = 1'b0;
        check_dut(0, req);
        check_dut(1, "R9");
    endtask

    task automatic do_reset();
        rst = 1'b1; iv = 1'b0; dl = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        mcnt[0] = 0; mcnt[1] = 0;
        check_dut(0, "R1");
        check_dut(1, "R1");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !done) begin
                done = 1'b1;
                fails++; checks++;
                $display("FAIL watchdog: cycles=%0d expected completion", cyc);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        string req;
        do_reset();
        for (int lvl = 0; lvl <= D; lvl++)
            for (int t = 0; t < (1 << TW); t++)
                for (int mode = 0; mode < 3; mode++) begin
                    bit tie = 1'b0;
                    do_reset();
                    for (int j = 0; j < lvl; j++) begin
                        do_op(1'b1, TW'((j * 3 + 1) & 7), 1'b0, "R2");
                        if (((j * 3 + 1) & 7) == t) tie = 1'b1;
                    end
                    if (mode == 0) req = (lvl == D) ? "R6" : (tie ? "R3" : "R2");
                    else if (mode == 1) req = "R5";
                    else req = (lvl == 0) ? "R7" : "R4";
                    do_op(mode != 2, TW'(t), mode != 0, req);
                end
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            bit ri, rr;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            ri = lf[0] | lf[1];
            rr = lf[2] & (lf[3] | ~lf[4]);
            req = lbl(ri, rr);
            do_op(ri, lf[7:5], rr, req);
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule